// File: doc/BRIEF.md
# Dual-Subsystem External Bus Handover

This block lets two processor subsystems, a master and a slave, share one external memory port during boot. System reset holds both subsystems in reset. When it is released, only the master's reset output goes high, and the master owns the external port. It uses the port to fetch its reset vector and to copy its code.

When the master is ready, it raises a select request. The block waits until no external access is pending and then moves ownership to the slave. After that, a release request from the master lets the slave out of reset. The slave then fetches its own reset vector over the port it now owns. Ownership passes once and only in that direction. Only a new system reset returns the block to its all-in-reset state. The owner-select level also chooses which subsystem's wait-state setting is sent to the external port.

Each request port and the external port use a valid/ready handshake. A transfer completes in the cycle in which valid and ready are both high. Read data is returned in that same cycle. A requester that has raised valid must hold valid, address, write data and write enable unchanged until ready is seen. The external ready is forwarded only to the port that currently holds the grant. The other port sees ready low and is stalled for as long as it lacks the grant.

Top module: `bus_handover`

## Requirements
- R1: While `rst_n` is low, `master_rst_n`, `slave_rst_n`, `owner_sel` and `ext_valid` are all 0.
- R2: `master_rst_n` rises at the first clock edge after `rst_n` goes high. From then on, with `owner_sel` = 0, the master's valid, address, write data and write enable appear on the external port, and `m_ready` equals `ext_ready`.
- R3: Ownership moves to the slave (`owner_sel` = 1) only after a `sel_req` sampled high while the master owns the port. A master transfer that is still pending (valid high, ready low) when `sel_req` is sampled completes on the master's side before `owner_sel` changes. `owner_sel` rises one cycle after the first cycle in which no access is pending.
- R4: Between `sel_req` being sampled and `owner_sel` rising, any master request that was not already pending is neither forwarded nor acknowledged: `ext_valid` = 0 and `m_ready` = 0.
- R5: `slave_rst_n` rises one cycle after `rel_req` is sampled high while `owner_sel` = 1. A `rel_req` raised before then is ignored and is not remembered. Once high, `slave_rst_n` stays high until the next system reset.
- R6: While `owner_sel` = 1, the slave's request fields appear on the external port, `s_ready` equals `ext_ready`, and `m_ready` is 0.
- R7: While `owner_sel` = 0, `s_ready` is 0 and the slave's request never reaches the external port.
- R8: `ext_wait_cfg` equals `m_wait_cfg` while `owner_sel` = 0 and `s_wait_cfg` while `owner_sel` = 1.
- R9: Asserting `rst_n` low after handover immediately returns all outputs to the state given in R1. A later release repeats the boot sequence from the master side.
- R10: Once `owner_sel` is 1, it stays 1 until system reset, whatever `sel_req` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| sel_req | input | 1 | Master's request to pass the port to the slave |
| rel_req | input | 1 | Master's request to release the slave's reset |
| master_rst_n | output | 1 | Master subsystem reset, active low |
| slave_rst_n | output | 1 | Slave subsystem reset, active low |
| owner_sel | output | 1 | Port owner: 0 master, 1 slave |
| m_valid | input | 1 | Master request valid |
| m_ready | output | 1 | Master request accepted |
| m_addr | input | ADDR_W | Master address |
| m_wdata | input | DATA_W | Master write data |
| m_we | input | 1 | Master write enable |
| m_rdata | output | DATA_W | Read data to master, valid with m_ready |
| m_wait_cfg | input | WAIT_W | Master wait-state setting |
| s_valid | input | 1 | Slave request valid |
| s_ready | output | 1 | Slave request accepted |
| s_addr | input | ADDR_W | Slave address |
| s_wdata | input | DATA_W | Slave write data |
| s_we | input | 1 | Slave write enable |
| s_rdata | output | DATA_W | Read data to slave, valid with s_ready |
| s_wait_cfg | input | WAIT_W | Slave wait-state setting |
| ext_valid | output | 1 | External request valid |
| ext_ready | input | 1 | External request accepted |
| ext_addr | output | ADDR_W | External address |
| ext_wdata | output | DATA_W | External write data |
| ext_we | output | 1 | External write enable |
| ext_rdata | input | DATA_W | External read data |
| ext_wait_cfg | output | WAIT_W | Wait-state setting of the current owner |

## Verification
The assertions check, on every cycle, the properties that hold in all states:
- the slave is never out of reset without owning the port;
- ownership and the two reset releases never fall back without a system reset;
- ownership never changes while an external access is pending;
- each requester is stalled while it lacks the grant.

The bench scenarios show the rest. They cover the order of events in the sequence, a release request raised too early being ignored, a pending master transfer finishing before the switch, new master requests being held back during the handover window, and a full reboot after reset.

// File: rtl/bus_handover_pkg.sv
package bus_handover_pkg;
  typedef enum logic [1:0] {
    ST_RESET_ALL   = 2'd0,
    ST_MASTER_BOOT = 2'd1,
    ST_HANDOVER    = 2'd2,
    ST_SLAVE_RUN   = 2'd3
  } hand_state_e;

  typedef enum logic [1:0] {
    GRANT_NONE   = 2'd0,
    GRANT_MASTER = 2'd1,
    GRANT_SLAVE  = 2'd2
  } grant_e;
endpackage

// File: rtl/handover_seq.sv
module handover_seq
  import bus_handover_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sel_req,
  input  logic   rel_req,
  input  logic   ext_valid,
  input  logic   ext_ready,
  output grant_e grant,
  output logic   master_rst_n,
  output logic   slave_rst_n,
  output logic   owner_sel
);
  hand_state_e state_q, state_d;
  logic        pend_q;
  logic        rel_q;

  // next-state logic for the one-way handover sequence
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET_ALL:   state_d = ST_MASTER_BOOT;
      ST_MASTER_BOOT: if (sel_req) state_d = ST_HANDOVER;
      ST_HANDOVER:    if (!pend_q) state_d = ST_SLAVE_RUN;
      ST_SLAVE_RUN:   state_d = ST_SLAVE_RUN;
      default:        state_d = ST_RESET_ALL;
    endcase
  end

  // grant: during handover the master keeps the port only to finish a pending access
  always_comb begin
    unique case (state_q)
      ST_MASTER_BOOT: grant = GRANT_MASTER;
      ST_HANDOVER:    grant = pend_q ? GRANT_MASTER : GRANT_NONE;
      ST_SLAVE_RUN:   grant = GRANT_SLAVE;
      default:        grant = GRANT_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RESET_ALL;
      pend_q  <= 1'b0;
      rel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= ext_valid & ~ext_ready;
      if (state_q == ST_SLAVE_RUN && rel_req) rel_q <= 1'b1;
    end
  end

  assign master_rst_n = (state_q != ST_RESET_ALL);
  assign owner_sel    = (state_q == ST_SLAVE_RUN);
  assign slave_rst_n  = rel_q;
endmodule

// File: rtl/handover_mux.sv
module handover_mux
  import bus_handover_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 3
) (
  input  grant_e              grant,
  input  logic                owner_sel,
  input  logic                m_valid,
  input  logic [ADDR_W-1:0]   m_addr,
  input  logic [DATA_W-1:0]   m_wdata,
  input  logic                m_we,
  input  logic [WAIT_W-1:0]   m_wait_cfg,
  output logic                m_ready,
  output logic [DATA_W-1:0]   m_rdata,
  input  logic                s_valid,
  input  logic [ADDR_W-1:0]   s_addr,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic                s_we,
  input  logic [WAIT_W-1:0]   s_wait_cfg,
  output logic                s_ready,
  output logic [DATA_W-1:0]   s_rdata,
  output logic                ext_valid,
  output logic [ADDR_W-1:0]   ext_addr,
  output logic [DATA_W-1:0]   ext_wdata,
  output logic                ext_we,
  output logic [WAIT_W-1:0]   ext_wait_cfg,
  input  logic                ext_ready,
  input  logic [DATA_W-1:0]   ext_rdata
);
  logic to_m, to_s;
  assign to_m = (grant == GRANT_MASTER);
  assign to_s = (grant == GRANT_SLAVE);

  always_comb begin
    ext_valid = 1'b0;
    ext_addr  = '0;
    ext_wdata = '0;
    ext_we    = 1'b0;
    if (to_m) begin
      ext_valid = m_valid;
      ext_addr  = m_addr;
      ext_wdata = m_wdata;
      ext_we    = m_we;
    end else if (to_s) begin
      ext_valid = s_valid;
      ext_addr  = s_addr;
      ext_wdata = s_wdata;
      ext_we    = s_we;
    end
  end

  assign m_ready      = to_m & ext_ready;
  assign s_ready      = to_s & ext_ready;
  assign m_rdata      = to_m ? ext_rdata : '0;
  assign s_rdata      = to_s ? ext_rdata : '0;
  assign ext_wait_cfg = owner_sel ? s_wait_cfg : m_wait_cfg;
endmodule

// File: rtl/bus_handover.sv
module bus_handover
  import bus_handover_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_req,
  input  logic              rel_req,
  output logic              master_rst_n,
  output logic              slave_rst_n,
  output logic              owner_sel,
  input  logic              m_valid,
  output logic              m_ready,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  input  logic              m_we,
  output logic [DATA_W-1:0] m_rdata,
  input  logic [WAIT_W-1:0] m_wait_cfg,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              s_we,
  output logic [DATA_W-1:0] s_rdata,
  input  logic [WAIT_W-1:0] s_wait_cfg,
  output logic              ext_valid,
  input  logic              ext_ready,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic              ext_we,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic [WAIT_W-1:0] ext_wait_cfg
);
  grant_e grant;

  handover_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_req      (sel_req),
    .rel_req      (rel_req),
    .ext_valid    (ext_valid),
    .ext_ready    (ext_ready),
    .grant        (grant),
    .master_rst_n (master_rst_n),
    .slave_rst_n  (slave_rst_n),
    .owner_sel    (owner_sel)
  );

  handover_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_mux (
    .grant        (grant),
    .owner_sel    (owner_sel),
    .m_valid      (m_valid),
    .m_addr       (m_addr),
    .m_wdata      (m_wdata),
    .m_we         (m_we),
    .m_wait_cfg   (m_wait_cfg),
    .m_ready      (m_ready),
    .m_rdata      (m_rdata),
    .s_valid      (s_valid),
    .s_addr       (s_addr),
    .s_wdata      (s_wdata),
    .s_we         (s_we),
    .s_wait_cfg   (s_wait_cfg),
    .s_ready      (s_ready),
    .s_rdata      (s_rdata),
    .ext_valid    (ext_valid),
    .ext_addr     (ext_addr),
    .ext_wdata    (ext_wdata),
    .ext_we       (ext_we),
    .ext_wait_cfg (ext_wait_cfg),
    .ext_ready    (ext_ready),
    .ext_rdata    (ext_rdata)
  );
endmodule

// File: rtl/bus_handover_chk.sv
module bus_handover_chk (
  input logic clk,
  input logic rst_n,
  input logic master_rst_n,
  input logic slave_rst_n,
  input logic owner_sel,
  input logic ext_valid,
  input logic ext_ready,
  input logic m_ready,
  input logic s_ready
);
  assert_slave_needs_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slave_rst_n |-> owner_sel);

  assert_slave_release_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slave_rst_n |=> slave_rst_n);

  assert_owner_one_way_R10: assert property (@(posedge clk) disable iff (!rst_n)
    owner_sel |=> owner_sel);

  assert_master_stays_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    master_rst_n |=> master_rst_n);

  assert_no_switch_in_flight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_valid && !ext_ready && !owner_sel) |=> !owner_sel);

  assert_master_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    owner_sel |-> !m_ready);

  assert_slave_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !owner_sel |-> !s_ready);
endmodule

bind bus_handover bus_handover_chk u_chk (.*);

// File: tb/tb_bus_handover.sv
`timescale 1ns/1ps
module tb_bus_handover;
  localparam int AW = 16, DW = 16, WW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, sel_req = 1'b0, rel_req = 1'b0;
  logic m_valid = 1'b0, m_we = 1'b0, s_valid = 1'b0, s_we = 1'b0, ext_ready = 1'b0;
  logic [AW-1:0] m_addr = '0, s_addr = '0;
  logic [DW-1:0] m_wdata = '0, s_wdata = '0, ext_rdata = '0;
  logic [WW-1:0] m_wait_cfg = 3'd7, s_wait_cfg = 3'd2;
  logic master_rst_n, slave_rst_n, owner_sel, m_ready, s_ready, ext_valid, ext_we;
  logic [DW-1:0] m_rdata, s_rdata, ext_wdata;
  logic [AW-1:0] ext_addr;
  logic [WW-1:0] ext_wait_cfg;

  bus_handover #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) dut (.*);

  int checks = 0, errors = 0;
  int mp = 0;       // model phase: 0 all reset, 1 master boot, 2 handover, 3 slave run
  bit mpend = 0, mrel = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit gm(); return (mp == 1) || (mp == 2 && mpend); endfunction
  function automatic bit gs(); return mp == 3; endfunction

  task automatic compare();
    logic ev;
    if (!rst_n) begin mp = 0; mpend = 0; mrel = 0; end
    ev = gm() ? m_valid : (gs() ? s_valid : 1'b0);
    chk("R2", "master_rst_n", master_rst_n, mp != 0);
    chk("R5", "slave_rst_n", slave_rst_n, mrel);
    chk("R3", "owner_sel", owner_sel, mp == 3);
    chk("R6", "ext_valid", ext_valid, ev);
    chk("R6", "ext_addr", ext_addr, gm() ? m_addr : (gs() ? s_addr : '0));
    chk("R6", "ext_wdata", ext_wdata, gm() ? m_wdata : (gs() ? s_wdata : '0));
    chk("R6", "ext_we", ext_we, gm() ? m_we : (gs() ? s_we : 1'b0));
    chk("R4", "m_ready", m_ready, gm() & ext_ready);
    chk("R7", "s_ready", s_ready, gs() & ext_ready);
    chk("R2", "m_rdata", m_rdata, gm() ? ext_rdata : '0);
    chk("R6", "s_rdata", s_rdata, gs() ? ext_rdata : '0);
    chk("R8", "ext_wait_cfg", ext_wait_cfg, (mp == 3) ? s_wait_cfg : m_wait_cfg);
  endtask

  task automatic update();
    logic ev;
    if (!rst_n) begin mp = 0; mpend = 0; mrel = 0; return; end
    ev = gm() ? m_valid : (gs() ? s_valid : 1'b0);
    if (mp == 3 && rel_req) mrel = 1;
    case (mp)
      0: mp = 1;
      1: if (sel_req) mp = 2;
      2: if (!mpend) mp = 3;
      default: mp = 3;
    endcase
    mpend = ev & ~ext_ready;
  endtask

  task automatic step();
    #1; compare();
    @(posedge clk); update(); #2;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(posedge clk); #2;
    repeat (3) step();
    #1;
    chk("R1", "master_rst_n in reset", master_rst_n, 0);
    chk("R1", "ext_valid in reset", ext_valid, 0);
    rst_n = 1'b1; step();
    // master boot traffic: direct accept, then a stalled accept
    m_valid = 1; m_addr = 16'hFF80; m_wdata = 16'h1234; m_we = 1; ext_ready = 1; ext_rdata = 16'hAAAA; step();
    m_addr = 16'h0100; m_we = 0; ext_ready = 0; step(); step();
    ext_ready = 1; ext_rdata = 16'h5A5A; step();
    m_valid = 0; ext_ready = 0;
    // early release request must be ignored
    rel_req = 1; step(); step(); rel_req = 0; step();
    // pending master access when handover requested
    m_valid = 1; m_addr = 16'h2222; m_wdata = 16'h0F0F; m_we = 1; ext_ready = 0; step();
    sel_req = 1; step(); sel_req = 0;
    for (int i = 0; i < 3; i++) begin
      #1; chk("R3", "owner held while pending", owner_sel, 0);
      chk("R3", "pending addr kept", ext_addr, 16'h2222);
      step();
    end
    ext_ready = 1; step();
    // new master request during handover window is blocked
    m_addr = 16'h3333; step();
    #1; chk("R4", "blocked master valid", ext_valid, 0);
    step(); step();
    #1; chk("R5", "slave still in reset after early request", slave_rst_n, 0);
    chk("R8", "slave wait cfg", ext_wait_cfg, s_wait_cfg);
    rel_req = 1; step(); rel_req = 0; step();
    // slave traffic, master stalled
    s_valid = 1; s_addr = 16'h0040; s_wdata = 16'hBEEF; s_we = 1; ext_ready = 0; step();
    ext_ready = 1; ext_rdata = 16'hC3C3; step();
    s_we = 0; s_addr = 16'h0041; step();
    sel_req = 1; step(); sel_req = 0; step();
    #1; chk("R10", "owner stays slave", owner_sel, 1);
    s_valid = 0; m_valid = 0; step();
    // system reset again
    rst_n = 0; #1;
    chk("R9", "slave reset reasserted", slave_rst_n, 0);
    chk("R9", "owner back to master", owner_sel, 0);
    chk("R9", "master reset reasserted", master_rst_n, 0);
    step(); step();
    rst_n = 1; step();
    m_valid = 1; m_addr = 16'h0777; ext_ready = 1; step();
    m_valid = 0; step(); step();
    finish_run();
  end
endmodule